// File: doc/BRIEF.md
# Interrupt and DMA Request Unit

This block collects the event flags of a serial bus controller into one status word and turns them into a single level-sensitive interrupt line and two DMA request lines, one for the receive direction and one for the transmit direction. The transfer engine raises status flags through a set vector and drops the two data-ready flags through a clear vector. Software sees the status word, a six-bit enable mask and a two-bit DMA configuration through plain per-register write strobes.

Software has three ways to act on the status word. A vector read returns the number of the lowest pending enabled source plus one and acknowledges that source in the same access. A status write clears only the acknowledgeable flags. A self-test command forces all six low flags high, so the interrupt path can be exercised. When DMA is switched on for a direction, the matching data-ready interrupt enable is turned off, so a request is never served twice.

Top module: `irqdma_unit`

## Requirements
- R1: `irq_o` is high exactly when status bits 5..0 ANDed with the enable mask are nonzero. Status bit k is enabled by mask bit k.
- R2: `rx_dma_req_o` equals status bit 3 (receive ready) while DMA config bit 15 is set, and is low otherwise. `tx_dma_req_o` equals status bit 4 (transmit ready) while DMA config bit 7 is set, and is low otherwise.
- R3: A DMA config write stores only data bits 15 and 7. Bit 15 set clears mask bit 3, and bit 7 set clears mask bit 4. This clear wins over a mask write in the same cycle.
- R4: `vec_o` is one plus the index of the lowest set bit of (status[5:0] AND mask), or 0 when that AND is zero. A `vec_rd_i` strobe clears that status bit at the clock edge.
- R5: A status write clears those status bits where the data bit is one and 16'h0027 has a one. Status bits 3 and 4 are never cleared by a status write.
- R6: A mask write stores data bits 5..0.
- R7: A self-test write whose data bit 11 is one sets status bits 5..0. With bit 11 zero, the write changes nothing.
- R8: `stat_o` bit 12 shows `bus_busy_i`. Status bit 12 is never stored, even when an event targets it.
- R9: An `evt_set_i` bit sets its status bit at the next edge. It takes priority over any clear of that bit in the same cycle, whether the clear comes from a status write, a vector read or `evt_clr_i`.
- R10: `irq_o`, `rx_dma_req_o` and `tx_dma_req_o` are registered. They reflect the status, mask and DMA state one clock after that state changes.
- R11: After reset, status, mask, DMA config and all three request outputs are zero.
- R12: An `evt_clr_i` bit clears its status bit at the next edge, unless the same bit is set in `evt_set_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 16 | Status set pulses from the transfer engine |
| evt_clr_i | input | 16 | Status clear pulses from the transfer engine |
| bus_busy_i | input | 1 | Bus-busy level, shown in status bit 12 |
| stat_wr_i | input | 1 | Status write (acknowledge) strobe |
| mask_wr_i | input | 1 | Enable-mask write strobe |
| dma_wr_i | input | 1 | DMA config write strobe |
| test_wr_i | input | 1 | Self-test command write strobe |
| vec_rd_i | input | 1 | Vector read strobe; acknowledges the reported source |
| wdata_i | input | 16 | Write data shared by all write strobes |
| stat_o | output | 16 | Status word with the busy flag merged in |
| mask_o | output | 6 | Enable mask |
| dma_cfg_o | output | 16 | DMA config (bits 15 and 7 only) |
| vec_o | output | 3 | Lowest pending enabled source plus one, or 0 |
| irq_o | output | 1 | Registered interrupt level |
| rx_dma_req_o | output | 1 | Registered receive DMA request |
| tx_dma_req_o | output | 1 | Registered transfer DMA request for the transmit direction |

## Verification
The assertions assume that reset is held for at least one clock before the first check, and that strobes and event vectors are clean single-cycle levels sampled at the rising edge. The same-cycle priority properties compare an event with the clears raised beside it. The acknowledge and force properties are written only for the cycles where no competing event or engine clear touches the same bit. The stimulus changes all inputs one nanosecond after a rising edge and returns them to idle after one cycle. It also provides the collision cases on purpose: an event together with a status write, and an event together with a vector read.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;
   // Variants of the lowest-set-bit finder
   typedef enum logic [0:0] {
      PRIO_SCAN = 1'b0,
      PRIO_ISOLATE = 1'b1
   } prio_impl_e;

   // Per-direction DMA enables
   typedef struct packed {
      logic rx_en;
      logic tx_en;
   } dma_en_t;
endpackage

// File: rtl/irqdma_prio_enc.sv
module irqdma_prio_enc
   import irqdma_pkg::*;
#(
   parameter int unsigned N = 6,
   parameter prio_impl_e IMPL = PRIO_SCAN,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     onehot_o
);
   logic [N-1:0] iso;

   assign iso      = req_i & (~req_i + {{(N-1){1'b0}}, 1'b1});
   assign any_o    = |req_i;
   assign onehot_o = iso;

   generate
      if (IMPL == PRIO_SCAN) begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) idx_o = IDX_W'(i);
            end
         end
      end else begin : g_iso
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < N; i++) begin
               if (iso[i]) idx_o = idx_o | IDX_W'(i);
            end
         end
      end
   endgenerate

   // R4: the index points at a set request with nothing set below it
   always_comb begin
      if (any_o) begin
         p_idx_lowest_r4: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
      end
   end
endmodule

// File: rtl/irqdma_cfg_regs.sv
module irqdma_cfg_regs #(
   parameter int unsigned SRC_W  = 6,
   parameter int unsigned RX_RDY = 3,
   parameter int unsigned TX_RDY = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mask_wr_i,
   input  logic [SRC_W-1:0]    mask_d_i,
   input  logic                dma_wr_i,
   input  logic                rx_en_d_i,
   input  logic                tx_en_d_i,
   output logic [SRC_W-1:0]    mask_o,
   output irqdma_pkg::dma_en_t dma_o
);
   logic [SRC_W-1:0]    mask_q, mask_nxt;
   irqdma_pkg::dma_en_t dma_q, dma_nxt;

   always_comb begin
      mask_nxt = mask_q;
      dma_nxt  = dma_q;
      if (mask_wr_i) mask_nxt = mask_d_i;
      if (dma_wr_i) begin
         dma_nxt.rx_en = rx_en_d_i;
         dma_nxt.tx_en = tx_en_d_i;
         if (rx_en_d_i) mask_nxt[RX_RDY] = 1'b0;
         if (tx_en_d_i) mask_nxt[TX_RDY] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         dma_q  <= '0;
      end else begin
         mask_q <= mask_nxt;
         dma_q  <= dma_nxt;
      end
   end

   assign mask_o = mask_q;
   assign dma_o  = dma_q;

   p_rx_dma_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr_i && rx_en_d_i) |=> !mask_q[RX_RDY]);
   p_tx_dma_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr_i && tx_en_d_i) |=> !mask_q[TX_RDY]);
   p_mask_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr_i && !dma_wr_i) |=> (mask_q == $past(mask_d_i)));
endmodule

// File: rtl/irqdma_status_reg.sv
module irqdma_status_reg #(
   parameter int unsigned STAT_W   = 16,
   parameter int unsigned SRC_W    = 6,
   parameter int unsigned RX_RDY   = 3,
   parameter int unsigned TX_RDY   = 4,
   parameter int unsigned BUSY_POS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] evt_set_i,
   input  logic [STAT_W-1:0] evt_clr_i,
   input  logic              sw_clr_en_i,
   input  logic [STAT_W-1:0] sw_bits_i,
   input  logic              ack_en_i,
   input  logic [STAT_W-1:0] ack_oh_i,
   input  logic              force_en_i,
   output logic [STAT_W-1:0] stat_o
);
   localparam logic [STAT_W-1:0] KEEP  = ~(STAT_W'(1) << BUSY_POS);
   localparam logic [STAT_W-1:0] FORCE = STAT_W'((64'd1 << SRC_W) - 64'd1);

   logic [STAT_W-1:0] stat_q, stat_nxt, set_eff;

   assign set_eff = evt_set_i & KEEP;

   always_comb begin
      stat_nxt = stat_q;
      if (ack_en_i)    stat_nxt = stat_nxt & ~ack_oh_i;
      if (sw_clr_en_i) stat_nxt = stat_nxt & ~sw_bits_i;
      stat_nxt = stat_nxt & ~evt_clr_i;
      if (force_en_i)  stat_nxt = stat_nxt | FORCE;
      stat_nxt = (stat_nxt | set_eff) & KEEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_nxt;
   end

   assign stat_o = stat_q;

   p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_eff != '0) |=> ((stat_q & $past(set_eff)) == $past(set_eff)));
   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en_i && ((ack_oh_i & evt_set_i) == '0)) |=> ((stat_q & $past(ack_oh_i)) == '0));
   p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (force_en_i && (evt_clr_i == '0)) |=> (&stat_q[SRC_W-1:0]));
   p_rx_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_en_i && !ack_en_i && !evt_clr_i[RX_RDY] && stat_q[RX_RDY]) |=> stat_q[RX_RDY]);
   p_tx_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_en_i && !ack_en_i && !evt_clr_i[TX_RDY] && stat_q[TX_RDY]) |=> stat_q[TX_RDY]);
   p_no_busy_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_q[BUSY_POS]);
endmodule

// File: rtl/irqdma_unit.sv
module irqdma_unit
   import irqdma_pkg::*;
#(
   parameter int unsigned STAT_W    = 16,
   parameter int unsigned SRC_W     = 6,
   parameter int unsigned RX_RDY    = 3,
   parameter int unsigned TX_RDY    = 4,
   parameter int unsigned RX_EN_POS = 15,
   parameter int unsigned TX_EN_POS = 7,
   parameter int unsigned BUSY_POS  = 12,
   parameter int unsigned FORCE_POS = 11,
   parameter logic [15:0] SW_CLR    = 16'h0027,
   parameter prio_impl_e  PRIO_IMPL = PRIO_SCAN,
   localparam int unsigned VEC_W    = $clog2(SRC_W + 1),
   localparam int unsigned IDX_W    = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] evt_set_i,
   input  logic [STAT_W-1:0] evt_clr_i,
   input  logic              bus_busy_i,
   input  logic              stat_wr_i,
   input  logic              mask_wr_i,
   input  logic              dma_wr_i,
   input  logic              test_wr_i,
   input  logic              vec_rd_i,
   input  logic [STAT_W-1:0] wdata_i,
   output logic [STAT_W-1:0] stat_o,
   output logic [SRC_W-1:0]  mask_o,
   output logic [STAT_W-1:0] dma_cfg_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              irq_o,
   output logic              rx_dma_req_o,
   output logic              tx_dma_req_o
);
   generate
      if (SRC_W > STAT_W || SRC_W < 1) begin : g_bad_src
         $error("SRC_W must lie in 1..STAT_W");
      end
      if (RX_RDY >= SRC_W || TX_RDY >= SRC_W || RX_RDY == TX_RDY) begin : g_bad_rdy
         $error("ready bits must be distinct and below SRC_W");
      end
      if (RX_EN_POS >= STAT_W || TX_EN_POS >= STAT_W || BUSY_POS >= STAT_W
          || FORCE_POS >= STAT_W || STAT_W > 16) begin : g_bad_pos
         $error("bit positions exceed the status width");
      end
   endgenerate

   logic [STAT_W-1:0] stat_q, ack_oh, sw_bits;
   logic [SRC_W-1:0]  mask_q, pend, pend_oh;
   dma_en_t           dma_q;
   logic              pend_any;
   logic [IDX_W-1:0]  pend_idx;
   logic              irq_q, rx_q, tx_q;

   irqdma_cfg_regs #(
      .SRC_W (SRC_W),
      .RX_RDY(RX_RDY),
      .TX_RDY(TX_RDY)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_wr_i(mask_wr_i),
      .mask_d_i (wdata_i[SRC_W-1:0]),
      .dma_wr_i (dma_wr_i),
      .rx_en_d_i(wdata_i[RX_EN_POS]),
      .tx_en_d_i(wdata_i[TX_EN_POS]),
      .mask_o   (mask_q),
      .dma_o    (dma_q)
   );

   assign pend = stat_q[SRC_W-1:0] & mask_q;

   irqdma_prio_enc #(
      .N   (SRC_W),
      .IMPL(PRIO_IMPL)
   ) u_prio (
      .req_i   (pend),
      .any_o   (pend_any),
      .idx_o   (pend_idx),
      .onehot_o(pend_oh)
   );

   generate
      if (STAT_W > SRC_W) begin : g_ext
         assign ack_oh = {{(STAT_W-SRC_W){1'b0}}, pend_oh};
      end else begin : g_noext
         assign ack_oh = pend_oh;
      end
   endgenerate

   assign sw_bits = wdata_i & SW_CLR[STAT_W-1:0];

   irqdma_status_reg #(
      .STAT_W  (STAT_W),
      .SRC_W   (SRC_W),
      .RX_RDY  (RX_RDY),
      .TX_RDY  (TX_RDY),
      .BUSY_POS(BUSY_POS)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_set_i  (evt_set_i),
      .evt_clr_i  (evt_clr_i),
      .sw_clr_en_i(stat_wr_i),
      .sw_bits_i  (sw_bits),
      .ack_en_i   (vec_rd_i & pend_any),
      .ack_oh_i   (ack_oh),
      .force_en_i (test_wr_i & wdata_i[FORCE_POS]),
      .stat_o     (stat_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rx_q  <= 1'b0;
         tx_q  <= 1'b0;
      end else begin
         irq_q <= |pend;
         rx_q  <= dma_q.rx_en & stat_q[RX_RDY];
         tx_q  <= dma_q.tx_en & stat_q[TX_RDY];
      end
   end

   always_comb begin
      dma_cfg_o            = '0;
      dma_cfg_o[RX_EN_POS] = dma_q.rx_en;
      dma_cfg_o[TX_EN_POS] = dma_q.tx_en;
      stat_o               = stat_q;
      stat_o[BUSY_POS]     = bus_busy_i;
   end

   assign mask_o       = mask_q;
   assign vec_o        = pend_any ? VEC_W'(pend_idx) + VEC_W'(1) : '0;
   assign irq_o        = irq_q;
   assign rx_dma_req_o = rx_q;
   assign tx_dma_req_o = tx_q;

   p_irq_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past((stat_o[SRC_W-1:0] & mask_o) != '0)));
   p_rx_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_dma_req_o == $past(dma_cfg_o[RX_EN_POS] & stat_o[RX_RDY])));
   p_tx_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tx_dma_req_o == $past(dma_cfg_o[TX_EN_POS] & stat_o[TX_RDY])));
endmodule

// File: tb/irqdma_unit_tb_top.sv
`timescale 1ns/100ps
module irqdma_unit_tb_top;
   localparam int SEL_STAT = 0, SEL_MASK = 1, SEL_DMA = 2, SEL_VEC = 3,
                  SEL_IRQ = 4, SEL_RX = 5, SEL_TX = 6;

   typedef struct {
      int          sel;
      logic [15:0] exp;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] evt_set = '0, evt_clr = '0, wdata = '0;
   logic bus_busy = 1'b0, stat_wr = 1'b0, mask_wr = 1'b0, dma_wr = 1'b0;
   logic test_wr = 1'b0, vec_rd = 1'b0;
   logic [15:0] stat_o, dma_cfg_o;
   logic [5:0]  mask_o;
   logic [2:0]  vec_o;
   logic irq_o, rx_o, tx_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   item_t sb[$];

   // bench model
   logic [15:0] m_stat = '0, m_dma = '0;
   logic [5:0]  m_mask = '0;

   always #2.5 clk = ~clk;

   irqdma_unit dut_i (
      .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
      .bus_busy_i(bus_busy), .stat_wr_i(stat_wr), .mask_wr_i(mask_wr),
      .dma_wr_i(dma_wr), .test_wr_i(test_wr), .vec_rd_i(vec_rd),
      .wdata_i(wdata), .stat_o(stat_o), .mask_o(mask_o), .dma_cfg_o(dma_cfg_o),
      .vec_o(vec_o), .irq_o(irq_o), .rx_dma_req_o(rx_o), .tx_dma_req_o(tx_o)
   );

   task automatic push(input int sel, input logic [15:0] exp, input string tag);
      item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compares queued expectations at the falling edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [15:0] got;
         it = sb.pop_front();
         case (it.sel)
            SEL_STAT: got = stat_o;
            SEL_MASK: got = {10'd0, mask_o};
            SEL_DMA:  got = dma_cfg_o;
            SEL_VEC:  got = {13'd0, vec_o};
            SEL_IRQ:  got = {15'd0, irq_o};
            SEL_RX:   got = {15'd0, rx_o};
            default:  got = {15'd0, tx_o};
         endcase
         checks++;
         if (got !== it.exp) begin
            failures++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
         end
      end
   end

   function automatic logic [2:0] model_vec();
      logic [5:0] p;
      p = m_stat[5:0] & m_mask;
      for (int i = 0; i < 6; i++) if (p[i]) return 3'(i + 1);
      return 3'd0;
   endfunction

   function automatic logic model_irq();
      return (m_stat[5:0] & m_mask) != 6'd0;
   endfunction

   // one access cycle; updates the model from the requirements
   task automatic op(input logic [15:0] set, input logic [15:0] clr, input bit swr,
                     input bit mwr, input bit dwr, input bit twr, input bit vrd,
                     input logic [15:0] wd);
      logic [15:0] ns;
      logic [5:0]  nm;
      logic [2:0]  v;
      @(posedge clk); #1;
      evt_set = set; evt_clr = clr; stat_wr = swr; mask_wr = mwr;
      dma_wr = dwr; test_wr = twr; vec_rd = vrd; wdata = wd;
      v = model_vec();
      if (vrd) push(SEL_VEC, {13'd0, v}, "R4 vector value");
      ns = m_stat;
      if (vrd && v != 0) ns[v-1] = 1'b0;
      if (swr) ns = ns & ~(wd & 16'h0027);
      ns = ns & ~clr;
      if (twr && wd[11]) ns = ns | 16'h003F;
      ns = (ns | set) & 16'hEFFF;
      nm = m_mask;
      if (mwr) nm = wd[5:0];
      if (dwr) begin
         m_dma = wd & 16'h8080;
         if (wd[15]) nm[3] = 1'b0;
         if (wd[7])  nm[4] = 1'b0;
      end
      m_stat = ns; m_mask = nm;
      @(posedge clk); #1;
      evt_set = '0; evt_clr = '0; stat_wr = 0; mask_wr = 0;
      dma_wr = 0; test_wr = 0; vec_rd = 0; wdata = '0;
   endtask

   task automatic check_regs(input string tag);
      push(SEL_STAT, m_stat | (16'(bus_busy) << 12), tag);
      push(SEL_MASK, {10'd0, m_mask}, tag);
      push(SEL_DMA, m_dma, tag);
   endtask

   task automatic check_outs(input string tag);
      @(posedge clk); #1;
      push(SEL_IRQ, {15'd0, model_irq()}, tag);
      push(SEL_RX, {15'd0, m_dma[15] & m_stat[3]}, tag);
      push(SEL_TX, {15'd0, m_dma[7] & m_stat[4]}, tag);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      check_regs("R11 reset regs");
      push(SEL_VEC, 16'd0, "R11 reset vector");
      check_outs("R11 reset outputs");
      // R8 busy flag merged into status
      @(posedge clk); #1 bus_busy = 1'b1;
      check_regs("R8 busy shown");
      @(posedge clk); #1 bus_busy = 1'b0;
      // R6 mask keeps low 6 bits
      op('0, '0, 0, 1, 0, 0, 0, 16'hFFFF);
      check_regs("R6 mask write");
      // R10 latency then R1 level
      op(16'h0022, '0, 0, 0, 0, 0, 0, '0);
      push(SEL_IRQ, 16'd0, "R10 irq not yet updated");
      check_outs("R1 irq asserted");
      // R4 vector reads: 2, 6, then 0
      op('0, '0, 0, 0, 0, 0, 1, '0);
      check_regs("R4 ack cleared bit 1");
      op('0, '0, 0, 0, 0, 0, 1, '0);
      op('0, '0, 0, 0, 0, 0, 1, '0);
      check_regs("R4 all acknowledged");
      check_outs("R1 irq low after acks");
      // R5 software clear limited to 0x27
      op(16'h003F, '0, 0, 0, 0, 0, 0, '0);
      op('0, '0, 1, 0, 0, 0, 0, 16'hFFFF);
      check_regs("R5 ready bits kept");
      check_outs("R2 no dma requests while disabled");
      // R3 dma config write
      op('0, '0, 0, 0, 1, 0, 0, 16'hFFFF);
      check_regs("R3 dma bits and mask cleared");
      check_outs("R2 both dma requests");
      // R12 engine clears receive ready
      op('0, 16'h0008, 0, 0, 0, 0, 0, '0);
      check_regs("R12 engine clear");
      check_outs("R12 rx request dropped");
      op('0, '0, 0, 0, 1, 0, 0, 16'h0000);
      check_outs("R2 requests off with dma disabled");
      // R7 self-test force
      op('0, '0, 0, 0, 0, 1, 0, 16'h0800);
      check_regs("R7 force low six");
      op('0, '0, 1, 0, 0, 0, 0, 16'h0027);
      op('0, '0, 0, 0, 0, 1, 0, 16'hF7FF);
      check_regs("R7 no force without bit 11");
      // R9 event beats software clear
      op(16'h0001, '0, 1, 0, 0, 0, 0, 16'h0001);
      check_regs("R9 event wins over status write");
      // R8 bit 12 never stored
      op(16'h1000, '0, 0, 0, 0, 0, 0, '0);
      check_regs("R8 bit 12 not stored");
      // R9 event beats vector acknowledge of same bit
      op(16'h0001, '0, 0, 0, 0, 0, 1, '0);
      check_regs("R9 event wins over vector ack");
      // R3 dma clear wins over same-cycle mask write
      op('0, '0, 0, 1, 1, 0, 0, 16'h8018);
      check_regs("R3 dma over mask write");
      check_outs("R1 final outputs");
      @(posedge clk); @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule